// File: doc/BRIEF.md
# Two-Wire Serial Register Target

This block is a slave-only two-wire serial target. An external master uses it to read and write a small byte-addressed register file. The block oversamples the clock line and the data line with a faster system clock. It recognises START, repeated START and STOP, and it answers to a 7-bit device address. The top four bits of that address are fixed. The low three bits are taken from a configuration byte that the bus itself can write. The block acknowledges bytes and shifts data most significant bit first. It only ever pulls the data line low or lets it go.

In a write transaction, the first data byte after the address sets a byte pointer. Each later byte is stored at the pointer, and the pointer then steps forward. A read transaction starts at the current pointer. The pointer steps after every byte it sends and wraps at the top of the register space. Values wider than a byte keep their high byte at the even address, so a master that reads upward from an even address receives the high byte first. The system clock must run at least eight times faster than the bus bit rate.

The interface is a wired bus with no valid/ready handshake, so there is no back-pressure. The master paces every transfer through the clock line, and this target never stretches it.

Top module: `twi_reg_target`

## Requirements
- R1: After reset, `sda_oe` is 0, the device address is 1001000, every register holds 0x00 and the byte pointer is 0.
- R2: A falling data line while the clock is high is a START, and a rising data line while the clock is high is a STOP. A STOP at any bit position returns the block to idle, and the next transaction is served normally.
- R3: A START with no STOP before it ends the current transaction and begins a new address phase.
- R4: Bytes are shifted most significant bit first, one bit per clock high pulse. The ninth pulse of each byte carries the acknowledge bit, where low means ACK and high means NAK.
- R5: The block pulls the data line low in the ninth bit only when the first 7 bits after a START equal its address. On a mismatch it leaves the line released until the next START.
- R6: Register 0 is the configuration byte. Its bits [2:0] form the low three address bits, and the upper four address bits are fixed at 1001. A new value takes effect at the next address phase.
- R7: In a write (R/W bit 0), the first data byte loads the pointer. Each later byte is stored at the pointer, and the pointer then increments. Every byte of a matched write is acknowledged.
- R8: In a read (R/W bit 1), the block sends the register at the current pointer, and the pointer increments after each byte. The pointer wraps from the last register to register 0. A word stored high byte at the even address comes out high byte first.
- R9: In a read, a NAK from the master ends the transfer. The block keeps the data line released until the next STOP or START.
- R10: `sda_oe` changes only while the synchronised clock line is low. When `sda_oe` is 1 the line is pulled low; otherwise it is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
Two pairs of functions can land on the same system clock edge.

- **Pointer load and register write.** On the falling edge that closes a written byte, the block both stores the byte and steps the pointer. A table of writes followed by read-backs at scattered addresses provokes this. A two-byte write at the top of the space followed by a three-byte read shows whether the store used the old pointer and whether the step wrapped.
- **Address decode and configuration write.** A write to the configuration byte changes the address that the very next address phase decodes. The bench rewrites it and then judges ACK or NAK for the old and new addresses.
- **Termination.** Repeated START and a STOP in the middle of a byte are issued while the engine is busy. Each must cut the transaction cleanly, which the bench judges by the response of the transaction that follows.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT
  } twi_state_e;
endpackage

// File: rtl/twi_sync_edge.sv
module twi_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start,
  output logic stop
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s    = scl_pipe[SYNC_STAGES-1];
  assign sda_s    = sda_pipe[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_regfile.sv
module twi_regfile #(
  parameter int REG_COUNT = 16,
  parameter int CFG_IDX   = 0,
  localparam int PTR_W    = $clog2(REG_COUNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [7:0]       rdata,
  output logic [2:0]       addr_lo
);
  logic [7:0] regs [REG_COUNT];

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[g] <= 8'h00;
      else if (wr_en && wr_addr == PTR_W'(g)) regs[g] <= wr_data;
    end
  end

  assign rdata   = regs[rd_addr];
  assign addr_lo = regs[CFG_IDX][2:0];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs[$past(wr_addr)] == $past(wr_data)); // R7
endmodule

// File: rtl/twi_engine.sv
module twi_engine
  import twi_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b1001,
  parameter int         PTR_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start,
  input  logic             stop,
  input  logic [2:0]       addr_lo,
  input  logic [7:0]       rdata,
  output logic             wr_en,
  output logic [PTR_W-1:0] ptr,
  output logic [7:0]       wr_data,
  output logic             sda_oe
);
  twi_state_e st;
  logic [3:0] bitcnt;
  logic [7:0] rx, tx;
  logic       rw, first, mack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bitcnt <= '0; rx <= '0; tx <= '0;
      rw <= 1'b0; first <= 1'b0; mack <= 1'b1; ptr <= '0; sda_oe <= 1'b0;
    end else if (start) begin
      st <= ST_ADDR; bitcnt <= '0; first <= 1'b1; sda_oe <= 1'b0;
    end else if (stop) begin
      st <= ST_IDLE; bitcnt <= '0; sda_oe <= 1'b0;
    end else begin
      if (scl_rise) begin
        if (st == ST_ADDR || st == ST_WDATA) rx <= {rx[6:0], sda_s};
        if (st == ST_RACK) mack <= sda_s;
        if (st != ST_IDLE && st != ST_WAIT) bitcnt <= bitcnt + 4'd1;
      end
      if (scl_fall) begin
        case (st)
          ST_ADDR: if (bitcnt == 4'd8) begin
            if (rx[7:1] == {ADDR_HI, addr_lo}) begin
              sda_oe <= 1'b1; rw <= rx[0]; st <= ST_AACK;
            end else begin
              st <= ST_WAIT;
            end
          end
          ST_AACK: if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            if (rw) begin
              st <= ST_RDATA; tx <= rdata; sda_oe <= ~rdata[7];
            end else begin
              st <= ST_WDATA; sda_oe <= 1'b0;
            end
          end
          ST_WDATA: if (bitcnt == 4'd8) begin
            sda_oe <= 1'b1; st <= ST_WACK; first <= 1'b0;
            if (first) ptr <= rx[PTR_W-1:0];
            else       ptr <= ptr + 1'b1;
          end
          ST_WACK: if (bitcnt == 4'd9) begin
            sda_oe <= 1'b0; bitcnt <= '0; st <= ST_WDATA;
          end
          ST_RDATA: if (bitcnt == 4'd8) begin
            sda_oe <= 1'b0; st <= ST_RACK; ptr <= ptr + 1'b1;
          end else if (bitcnt != 4'd0) begin
            tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6];
          end
          ST_RACK: if (bitcnt == 4'd9) begin
            if (!mack) begin
              bitcnt <= '0; tx <= rdata; sda_oe <= ~rdata[7]; st <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0; st <= ST_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_en   = (st == ST_WDATA) && scl_fall && (bitcnt == 4'd8) && !first;
  assign wr_data = rx;

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE || st == ST_WAIT) |-> !sda_oe); // R9
  AST_OE_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R10
  AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd9); // R4
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> (st == ST_IDLE && !sda_oe)); // R2
endmodule

// File: rtl/twi_reg_target.sv
module twi_reg_target #(
  parameter int         REG_COUNT = 16,
  parameter logic [3:0] ADDR_HI   = 4'b1001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int PTR_W = $clog2(REG_COUNT);

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic wr_en;
  logic [PTR_W-1:0] ptr;
  logic [7:0] wr_data, rdata;
  logic [2:0] addr_lo;

  twi_sync_edge #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start(start), .stop(stop)
  );

  twi_engine #(.ADDR_HI(ADDR_HI), .PTR_W(PTR_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start(start), .stop(stop),
    .addr_lo(addr_lo), .rdata(rdata), .wr_en(wr_en), .ptr(ptr),
    .wr_data(wr_data), .sda_oe(sda_oe)
  );

  twi_regfile #(.REG_COUNT(REG_COUNT), .CFG_IDX(0)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr), .wr_data(wr_data),
    .rd_addr(ptr), .rdata(rdata), .addr_lo(addr_lo)
  );
endmodule

// File: tb/test_twi_reg_target.sv
module test_twi_reg_target;
  localparam int QT = 10;

  typedef struct packed {
    logic       rd;
    logic [7:0] ptr;
    logic [7:0] data;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b0, 8'd3,  8'hA5}, '{1'b0, 8'd7,  8'h3C}, '{1'b1, 8'd3,  8'hA5},
    '{1'b0, 8'd2,  8'h12}, '{1'b1, 8'd7,  8'h3C}, '{1'b0, 8'd15, 8'hF0},
    '{1'b1, 8'd15, 8'hF0}, '{1'b0, 8'd8,  8'h81}, '{1'b1, 8'd8,  8'h81},
    '{1'b1, 8'd2,  8'h12}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   n_chk = 0;
  int   n_fail = 0;

  always #2.5 clk = ~clk;

  twi_reg_target i_twi_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (QT) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic wbit(input logic b);
    sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); b = sda_line; q(); scl_m = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(ack);
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic mack);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    wbit(mack);
  endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d, output logic ok);
    logic k0, k1, k2;
    bus_start(); send_byte({a, 1'b0}, k0); send_byte(p, k1); send_byte(d, k2); bus_stop();
    ok = !k0 && !k1 && !k2;
  endtask

  task automatic rd1(input logic [6:0] a, input logic [7:0] p, output logic [7:0] d, output logic ok);
    logic k0, k1, k2;
    bus_start(); send_byte({a, 1'b0}, k0); send_byte(p, k1);
    bus_start(); send_byte({a, 1'b1}, k2); recv_byte(d, 1'b1); bus_stop();
    ok = !k0 && !k1 && !k2;
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ok, k, k2;
    logic [7:0] d, d1, d2;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 oe in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 oe after reset", int'(sda_oe), 0);
    rd1(7'h48, 8'd5, d, ok);
    chk(ok && d == 8'h00, "R1 default address and zero regs", int'(d), 0);

    // table walk: R7 writes, R8 reads, R3 repeated start inside rd1, R4 bit order
    foreach (VECS[i]) begin
      if (VECS[i].rd) begin
        rd1(7'h48, VECS[i].ptr, d, ok);
        chk(ok, "R3 read transaction acks", int'(ok), 1);
        chk(d == VECS[i].data, "R8 R4 read data", int'(d), int'(VECS[i].data));
      end else begin
        wr1(7'h48, VECS[i].ptr, VECS[i].data, ok);
        chk(ok, "R7 write acks", int'(ok), 1);
      end
    end

    // R5: wrong address gets NAK, line stays released
    bus_start(); send_byte({7'h4A, 1'b0}, k); send_byte(8'h00, k2); bus_stop();
    chk(k == 1'b1, "R5 mismatch NAK", int'(k), 1);
    chk(k2 == 1'b1, "R5 ignored after mismatch", int'(k2), 1);

    // R6: configuration byte moves the address
    wr1(7'h48, 8'd0, 8'h05, ok);
    chk(ok, "R6 config write", int'(ok), 1);
    bus_start(); send_byte({7'h48, 1'b0}, k); bus_stop();
    chk(k == 1'b1, "R6 old address NAK", int'(k), 1);
    rd1(7'h4D, 8'd0, d, ok);
    chk(ok && d == 8'h05, "R6 new address serves", int'(d), 5);
    wr1(7'h4D, 8'd0, 8'h00, ok);
    chk(ok, "R6 restore", int'(ok), 1);

    // R7/R8: word at even address 14 (high byte BE), read across the wrap
    bus_start(); send_byte({7'h48, 1'b0}, k); send_byte(8'd14, k);
    send_byte(8'hBE, k); send_byte(8'hEF, k2); bus_stop();
    chk(!k && !k2, "R7 multi-byte write acks", int'(k | k2), 0);
    bus_start(); send_byte({7'h48, 1'b0}, k); send_byte(8'd14, k);
    bus_start(); send_byte({7'h48, 1'b1}, k);
    recv_byte(d, 1'b0); recv_byte(d1, 1'b0); recv_byte(d2, 1'b1);
    chk(d == 8'hBE, "R8 high byte first", int'(d), 'hBE);
    chk(d1 == 8'hEF, "R8 auto increment", int'(d1), 'hEF);
    chk(d2 == 8'h00, "R8 wrap to reg 0", int'(d2), 0);
    // R9: after NAK, further clocks read a released line
    recv_byte(d, 1'b1);
    chk(d == 8'hFF, "R9 released after NAK", int'(d), 'hFF);
    bus_stop();

    // R2: stop in the middle of a byte, then normal service
    bus_start(); send_byte({7'h48, 1'b0}, k);
    wbit(1'b0); wbit(1'b1); wbit(1'b1); wbit(1'b0);
    bus_stop();
    rd1(7'h48, 8'd3, d, ok);
    chk(ok && d == 8'hA5, "R2 stop mid-byte recovers", int'(d), 'hA5);

    // R3: repeated start after a mismatched address
    bus_start(); send_byte({7'h11, 1'b0}, k);
    bus_start(); send_byte({7'h48, 1'b0}, k2); bus_stop();
    chk(k == 1'b1 && k2 == 1'b0, "R3 Sr starts new address phase", int'({k, k2}), 2);

    // R10: oe idle after everything
    repeat (20) @(negedge clk);
    chk(sda_oe == 1'b0, "R10 released at idle", int'(sda_oe), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule